// File: doc/BRIEF.md
# Circular-Arc Step Interpolator with Merged Diagonal Steps

This block turns a circular arc into unit step pulses on two axes for a stepper-driven tool. The arc is centred on the origin. The caller supplies a signed start point, a signed end point, a rotation sense and a power-of-two gain, then pulses `start`. After that, every pulse on `tick` runs one iteration, so the step rate is set by whoever drives `tick`. Each axis has a signed accumulator. The X accumulator integrates the magnitude of the Y coordinate, and the Y accumulator integrates the magnitude of the X coordinate. When an accumulator passes its modulus, that axis takes one step.

On a plain digital differential analyser, an X step in one iteration is often followed by a Y step in the next. That pair forms a small stair on the path. This block avoids the stair. When only one axis overflows, the other axis's next addition is tried early, in the same iteration. If that early sum also overflows, both axes step together as one diagonal move, and the second accumulator is left negative by the amount it borrowed. Integrands are scaled by a left shift chosen at start time, so the step rate does not depend on the arc's size. An axis stops stepping once its remaining distance is zero. A done flag rises when both remaining distances are within the tolerance.

Top module: `dda_arc_interp`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `step_x`, `step_y` and `done` are low.
- R2: A cycle with `start` high loads the points, the rotation sense and the gain, and clears both accumulators. No step is issued in the clock that follows. `done` then reads 1 exactly when the start point is within `END_TOL` (default 0) of the end point on both axes. Otherwise it reads 0.
- R3: An iteration runs only in a cycle with `tick` high while the arc is active. Each step output is a one-clock pulse in the clock after that tick. No step follows a cycle with `tick` low.
- R4: The shift is s = N + `weight_sel`, where `weight_sel` 0,1,2,3 selects a gain of 1,2,4,8. The X integrand is max(|y|,1) shifted left by s, and the Y integrand is max(|x|,1) shifted left by s. Each accumulator adds its integrand every iteration and overflows when its sum reaches M = 2^(CW+2). The axis then steps and the accumulator keeps the sum minus M.
- R5: If exactly one axis overflows, the other axis also steps when its sum plus its integrand reaches M. In that case its accumulator keeps its sum minus M, which is negative.
- R6: N is the smallest left shift that brings the bit length of the largest start or end coordinate magnitude up to CW-2. N is 0 when every coordinate is zero. Magnitudes must stay below 2^(CW-2).
- R7: `dir_x`/`dir_y` are 1 for a step toward negative values. With `ccw`=1, X moves negative when y>0 and Y moves negative when x<0. With `ccw`=0, both senses are reversed. If the other coordinate is zero, the axis moves toward its own end value.
- R8: An axis whose remaining distance to its end coordinate is zero neither steps nor changes its accumulator.
- R9: After an iteration that leaves both remaining distances within `END_TOL`, `done` rises in the next clock. It stays high, with no further steps, until the next `start`.
- R10: The arc from (8,0) to (0,8), turning counter-clockwise, finishes exactly at (0,8).
- R11: A `start` while an arc is running abandons that arc and begins the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load a new arc |
| tick | input | 1 | Run one iteration |
| ccw | input | 1 | 1 = counter-clockwise, 0 = clockwise |
| weight_sel | input | 2 | Gain select, shift of 0..3 |
| x_start | input | CW | Signed start X |
| y_start | input | CW | Signed start Y |
| x_end | input | CW | Signed end X |
| y_end | input | CW | Signed end Y |
| step_x | output | 1 | One-clock X step pulse |
| dir_x | output | 1 | X direction, 1 = negative |
| step_y | output | 1 | One-clock Y step pulse |
| dir_y | output | 1 | Y direction, 1 = negative |
| done | output | 1 | Arc finished |

## Verification
A behavioural model in the bench runs alongside the design and is compared with it every clock. The stimulus exercises all four gains, both rotation senses, arcs that start on an axis where one integrand is zero, a zero-length arc, and a restart in the middle of an arc. If the early-addition rule is missing, the X and Y steps land in separate cycles where the model expects one diagonal step. If the borrow is not kept as a negative value, the step spacing after a merge drifts from the model. If an axis is not gated, or the zero-coordinate direction rule is wrong, the tool overshoots and the accumulated position misses the end point, or `done` never rises and the watchdog expires. Bad restart handling shows up as leftover steps, or a stale position, after the second `start`.

// File: rtl/dda_arc_pkg.sv
package dda_arc_pkg;

    // Per-axis move decision for one iteration.
    typedef struct packed {
        logic fire;
        logic neg;
    } move_t;

    // Index of the highest set bit; 0 for a zero input.
    function automatic int unsigned top_bit(input int unsigned v);
        int unsigned p;
        p = 0;
        for (int i = 0; i < 32; i++) begin
            if (v[i]) p = i;
        end
        return p;
    endfunction

    // Left shift that lifts the top bit of mag up to bit position tgt.
    function automatic int unsigned lift_shift(input int unsigned mag, input int unsigned tgt);
        int unsigned p;
        if (mag == 0) return 0;
        p = top_bit(mag);
        return (p >= tgt) ? 0 : (tgt - p);
    endfunction

    function automatic int unsigned magnitude(input int v);
        return (v < 0) ? int'(-v) : int'(v);
    endfunction

    // Absolute distance between two signed coordinates.
    function automatic int unsigned span(input int a, input int b);
        return magnitude(b - a);
    endfunction

    // Direction of a step: 1 = toward negative values.
    // other: coordinate on the crossing axis, own/own_end: this axis.
    function automatic logic axis_negative(input int other, input int own,
                                           input int own_end, input logic ccw,
                                           input logic is_y);
        if (other != 0) return (ccw ^ is_y) ? (other > 0) : (other < 0);
        return own_end < own;
    endfunction

endpackage

// File: rtl/dda_integrand.sv
module dda_integrand #(
    parameter int CW  = 12,
    parameter int IW  = CW + 2,
    parameter int SHW = 4
) (
    input  logic signed [CW-1:0] coord,
    input  logic [SHW-1:0]       shift,
    output logic [IW-1:0]        value
);
    logic [CW-1:0] mag;
    logic [CW-1:0] mag_floor;

    always_comb begin
        mag       = coord[CW-1] ? CW'(-coord) : CW'(coord);
        // A zero integrand would stall an axis that still has distance left.
        mag_floor = (mag == '0) ? CW'(1) : mag;
        value     = IW'(mag_floor) << shift;
    end
endmodule

// File: rtl/dda_acc_pair.sv
module dda_acc_pair #(
    parameter int IW = 14,
    parameter int AW = IW + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic                iterate,
    input  logic [1:0]          enable,
    input  logic [1:0][IW-1:0]  integrand,
    output logic [1:0]          fire
);
    localparam int LW = AW + 1;
    localparam logic signed [LW-1:0] MODL = {{(LW-IW-1){1'b0}}, 1'b1, {IW{1'b0}}};

    logic signed [AW-1:0] acc    [2];
    logic signed [LW-1:0] sum    [2];
    logic signed [LW-1:0] addend [2];
    logic signed [LW-1:0] nxt    [2];
    logic [1:0]           ovf;
    logic [1:0]           ahead;

    for (genvar a = 0; a < 2; a++) begin : g_axis
        always_comb begin
            addend[a] = $signed({{(LW-IW){1'b0}}, integrand[a]});
            sum[a]    = LW'(acc[a]) + addend[a];
            ovf[a]    = enable[a] && (sum[a] >= MODL);
            // Next iteration's addition, tried early.
            ahead[a]  = enable[a] && ((sum[a] + addend[a]) >= MODL);
        end

        // Own overflow, or a borrow merged with the other axis's overflow.
        assign fire[a] = ovf[a] | (ovf[1-a] & ahead[a]);
        assign nxt[a]  = fire[a] ? (sum[a] - MODL) : sum[a];

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                acc[a] <= '0;
            end else if (iterate && enable[a]) begin
                acc[a] <= AW'(nxt[a]);
            end
        end
    end
endmodule

// File: rtl/dda_arc_interp.sv
module dda_arc_interp
    import dda_arc_pkg::*;
#(
    parameter int          CW      = 12,
    parameter int unsigned END_TOL = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic                 tick,
    input  logic                 ccw,
    input  logic [1:0]           weight_sel,
    input  logic signed [CW-1:0] x_start,
    input  logic signed [CW-1:0] y_start,
    input  logic signed [CW-1:0] x_end,
    input  logic signed [CW-1:0] y_end,
    output logic                 step_x,
    output logic                 dir_x,
    output logic                 step_y,
    output logic                 dir_y,
    output logic                 done
);
    localparam int IW       = CW + 2;
    localparam int AW       = IW + 2;
    localparam int SHW      = $clog2(CW + 1);
    localparam int NORM_TOP = CW - 3;

    logic signed [CW-1:0] cur_x, cur_y, tgt_x, tgt_y;
    logic signed [CW-1:0] nxt_x, nxt_y;
    logic [SHW-1:0]       norm_q;
    logic [1:0]           wsel_q;
    logic                 ccw_q;
    logic                 busy_q;
    logic                 done_q;
    logic                 iterate;
    logic [SHW-1:0]       shift;
    logic [1:0][IW-1:0]   integrand;
    logic [1:0]           enable;
    logic [1:0]           fire;
    move_t                mv_x, mv_y;
    logic                 fin_next;
    logic                 fin_load;
    int unsigned          peak;

    assign iterate = tick && busy_q && !start;
    assign shift   = norm_q + SHW'(wsel_q);

    // X integrates the Y coordinate, Y integrates the X coordinate.
    dda_integrand #(.CW(CW), .IW(IW), .SHW(SHW)) u_ig_x (
        .coord(cur_y), .shift(shift), .value(integrand[0])
    );
    dda_integrand #(.CW(CW), .IW(IW), .SHW(SHW)) u_ig_y (
        .coord(cur_x), .shift(shift), .value(integrand[1])
    );

    assign enable[0] = span(int'(cur_x), int'(tgt_x)) != 0;
    assign enable[1] = span(int'(cur_y), int'(tgt_y)) != 0;

    dda_acc_pair #(.IW(IW), .AW(AW)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .clear    (start),
        .iterate  (iterate),
        .enable   (enable),
        .integrand(integrand),
        .fire     (fire)
    );

    always_comb begin
        mv_x.fire = fire[0];
        mv_x.neg  = axis_negative(int'(cur_y), int'(cur_x), int'(tgt_x), ccw_q, 1'b0);
        mv_y.fire = fire[1];
        mv_y.neg  = axis_negative(int'(cur_x), int'(cur_y), int'(tgt_y), ccw_q, 1'b1);

        nxt_x = cur_x;
        nxt_y = cur_y;
        if (mv_x.fire) nxt_x = mv_x.neg ? cur_x - CW'(1) : cur_x + CW'(1);
        if (mv_y.fire) nxt_y = mv_y.neg ? cur_y - CW'(1) : cur_y + CW'(1);

        fin_next = (span(int'(nxt_x), int'(tgt_x)) <= END_TOL) &&
                   (span(int'(nxt_y), int'(tgt_y)) <= END_TOL);
        fin_load = (span(int'(x_start), int'(x_end)) <= END_TOL) &&
                   (span(int'(y_start), int'(y_end)) <= END_TOL);

        peak = magnitude(int'(x_start));
        if (magnitude(int'(y_start)) > peak) peak = magnitude(int'(y_start));
        if (magnitude(int'(x_end))   > peak) peak = magnitude(int'(x_end));
        if (magnitude(int'(y_end))   > peak) peak = magnitude(int'(y_end));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_x  <= '0;
            cur_y  <= '0;
            tgt_x  <= '0;
            tgt_y  <= '0;
            norm_q <= '0;
            wsel_q <= '0;
            ccw_q  <= 1'b0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            step_x <= 1'b0;
            step_y <= 1'b0;
            dir_x  <= 1'b0;
            dir_y  <= 1'b0;
        end else if (start) begin
            cur_x  <= x_start;
            cur_y  <= y_start;
            tgt_x  <= x_end;
            tgt_y  <= y_end;
            norm_q <= SHW'(lift_shift(peak, NORM_TOP));
            wsel_q <= weight_sel;
            ccw_q  <= ccw;
            busy_q <= !fin_load;
            done_q <= fin_load;
            step_x <= 1'b0;
            step_y <= 1'b0;
        end else begin
            step_x <= iterate && mv_x.fire;
            step_y <= iterate && mv_y.fire;
            if (iterate) begin
                cur_x  <= nxt_x;
                cur_y  <= nxt_y;
                busy_q <= !fin_next;
                done_q <= fin_next;
                if (mv_x.fire) dir_x <= mv_x.neg;
                if (mv_y.fire) dir_y <= mv_y.neg;
            end
        end
    end

    assign done = done_q;
endmodule

// File: rtl/dda_arc_interp_chk.sv
module dda_arc_interp_chk (
    input logic clk,
    input logic rst,
    input logic start,
    input logic tick,
    input logic step_x,
    input logic step_y,
    input logic done
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!step_x && !step_y && !done));

    // R2
    load_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!step_x && !step_y));

    // R3
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> (!step_x && !step_y));

    // R9
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9
    done_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (!step_x && !step_y));
endmodule

bind dda_arc_interp dda_arc_interp_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .tick  (tick),
    .step_x(step_x),
    .step_y(step_y),
    .done  (done)
);

// File: tb/dda_arc_interp_tb_top.sv
module dda_arc_interp_tb_top;
    localparam int CW = 12;
    localparam int M  = 1 << (CW + 2);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic tick = 1'b0;
    logic ccw = 1'b0;
    logic [1:0] weight_sel = 2'd0;
    logic signed [CW-1:0] x_start = '0, y_start = '0, x_end = '0, y_end = '0;
    logic step_x, dir_x, step_y, dir_y, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dda_arc_interp #(.CW(CW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .tick(tick), .ccw(ccw),
        .weight_sel(weight_sel), .x_start(x_start), .y_start(y_start),
        .x_end(x_end), .y_end(y_end), .step_x(step_x), .dir_x(dir_x),
        .step_y(step_y), .dir_y(dir_y), .done(done)
    );

    // Reference model state
    int mx, my, mxe, myey, macx, macy, mshift;
    bit mccw, mbusy;
    bit e_sx, e_sy, e_dx, e_dy, e_done;

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int norm_of(input int m);
        int n;
        n = 0;
        if (m > 0) while ((m << n) < (1 << (CW - 3))) n++;
        return n;
    endfunction

    always @(posedge clk) begin
        int ix, iy, sx, sy, pk;
        bit enx, eny, ox, oy, fx, fy, nx, ny;
        e_sx = 0;
        e_sy = 0;
        if (rst) begin
            mbusy = 0;
            e_done = 0;
            e_dx = 0;
            e_dy = 0;
        end else if (start) begin
            mx = x_start; my = y_start; mxe = x_end; myey = y_end;
            macx = 0; macy = 0; mccw = ccw;
            pk = iabs(mx);
            if (iabs(my) > pk) pk = iabs(my);
            if (iabs(mxe) > pk) pk = iabs(mxe);
            if (iabs(myey) > pk) pk = iabs(myey);
            mshift = norm_of(pk) + int'(weight_sel);
            e_done = (mx == mxe) && (my == myey);
            mbusy = !e_done;
        end else if (tick && mbusy) begin
            ix = ((my == 0) ? 1 : iabs(my)) << mshift;
            iy = ((mx == 0) ? 1 : iabs(mx)) << mshift;
            enx = (mx != mxe);
            eny = (my != myey);
            sx = macx + ix;
            sy = macy + iy;
            ox = enx && (sx >= M);
            oy = eny && (sy >= M);
            fx = ox || (oy && enx && (sx + ix >= M));
            fy = oy || (ox && eny && (sy + iy >= M));
            if (my != 0) nx = mccw ? (my > 0) : (my < 0);
            else nx = (mxe < mx);
            if (mx != 0) ny = mccw ? (mx < 0) : (mx > 0);
            else ny = (myey < my);
            if (enx) macx = fx ? sx - M : sx;
            if (eny) macy = fy ? sy - M : sy;
            if (fx) begin mx = nx ? mx - 1 : mx + 1; e_dx = nx; end
            if (fy) begin my = ny ? my - 1 : my + 1; e_dy = ny; end
            e_sx = fx;
            e_sy = fy;
            e_done = (mx == mxe) && (my == myey);
            mbusy = !e_done;
        end
    end

    // Position integrated from the step outputs
    int px = 0, py = 0;

    // Every-clock comparison (R1 R3 R4 R5 R6 R7 R8 R9)
    always @(negedge clk) begin
        if (!finished) begin
            checks++;
            if (step_x !== e_sx || step_y !== e_sy || done !== e_done ||
                (step_x && dir_x !== e_dx) || (step_y && dir_y !== e_dy)) begin
                errors++;
                $display("FAIL R4 R5 R7 cycle compare: got sx%0b sy%0b dx%0b dy%0b done%0b, expected sx%0b sy%0b dx%0b dy%0b done%0b",
                         step_x, step_y, dir_x, dir_y, done, e_sx, e_sy, e_dx, e_dy, e_done);
            end
            if (step_x) px = dir_x ? px - 1 : px + 1;
            if (step_y) py = dir_y ? py - 1 : py + 1;
        end
    end

    task automatic check(input bit ok, input string req, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // abort_after > 0: leave the arc running after that many cycles
    task automatic run_arc(input int xs, input int ys, input int xe, input int ye,
                           input bit dir_ccw, input int w, input int gap,
                           input int abort_after, input string tag);
        int cnt;
        @(negedge clk);
        x_start = CW'(xs); y_start = CW'(ys); x_end = CW'(xe); y_end = CW'(ye);
        ccw = dir_ccw; weight_sel = 2'(w); start = 1'b1; tick = 1'b1;
        @(negedge clk);
        start = 1'b0; tick = 1'b0;
        px = xs; py = ys;
        // R2: load cycle issues no step; done only for a zero-length arc
        check(!step_x && !step_y, "R2 step after load", int'(step_x) + int'(step_y), 0);
        check(done == ((xs == xe) && (ys == ye)), "R2 done after load", int'(done),
              int'((xs == xe) && (ys == ye)));
        cnt = 0;
        while (!done && !(abort_after > 0 && cnt >= abort_after) && cnt < 60000) begin
            tick = (cnt % gap) == 0;
            @(negedge clk);
            cnt++;
        end
        tick = 1'b0;
        if (abort_after > 0) return;
        @(posedge clk);
        check(px == xe, {tag, " final x"}, px, xe);
        check(py == ye, {tag, " final y"}, py, ye);
        // R9: extra ticks after done produce nothing
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            check(done && !step_x && !step_y, "R9 idle after done", int'(done), 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!step_x && !step_y && !done, "R1 reset outputs", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!step_x && !step_y && !done, "R1 after reset", int'(done), 0);

        run_arc(8, 0, 0, 8, 1'b1, 0, 1, 0, "R10");
        run_arc(0, 8, 8, 0, 1'b0, 2, 3, 0, "R7 cw");
        run_arc(0, -20, 20, 0, 1'b1, 3, 2, 0, "R4 R6 gain8");
        run_arc(-30, 0, 0, -30, 1'b1, 1, 1, 0, "R5 R8 gain2");
        run_arc(5, 5, 5, 5, 1'b1, 0, 1, 0, "R2 zero arc");
        run_arc(100, 0, 0, 100, 1'b1, 0, 1, 300, "R11 abort");
        run_arc(0, 50, -50, 0, 1'b1, 2, 1, 0, "R11 restart");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired, got running expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule